// File: doc/BRIEF.md
# Peripheral Clock Gate Bank

This block holds the clock-enable state for up to 64 peripherals and drives one registered clock-enable line per peripheral. Software uses a simple synchronous register bus with an address, write data, a write strobe and a combinational read-data return. The enable bits sit in 32-bit banks. Each bank has three registers: a set register, a clear register and a status register. Set and clear are write-one-to-act, so a single bus write can switch any group of peripherals without a read-modify-write sequence.

The two lowest peripheral IDs are never gated. Their enable lines are tied high and report as enabled. Every other clock starts off after reset and stays off until software sets it. The clock-enable outputs are meant to drive the glitch-free gating cells that sit outside this block.

Top module: `pclk_gate_bank`

## Requirements
- R1: A write to a bank's set register sets the enable bit of every peripheral whose data bit is 1.
- R2: A write to a bank's clear register clears the enable bit of every gateable peripheral whose data bit is 1.
- R3: Data bits written as 0 to a set or clear register leave the matching enable bits unchanged.
- R4: A read of a bank's status register returns that bank's current enable state. Peripheral ID n appears at bit (n mod 32).
- R5: Word address bits [3:2] select the bank (0 for IDs 0 to 31, 1 for IDs 32 to 63). Address bits [1:0] select the register: 0 is set, 1 is clear, 2 is status. Each write reaches exactly one register.
- R6: Peripheral IDs 0 and 1 always read as enabled and drive a 1 on their enable lines. Set and clear writes to them have no effect.
- R7: Reset clears every gateable enable bit. After reset only IDs 0 and 1 are on.
- R8: Reads of set, clear or unmapped addresses return zero. Writes to status or unmapped addresses (offset 3, or bank field 2 or 3) change nothing.
- R9: The enable outputs are registered. They hold their value while the write strobe is high and change one cycle after it.
- R10: All 64 IDs are supported. ID 32 is bit 0 and ID 63 is bit 31 of the second bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and state clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Combinational read data |
| clk_en_o | output | 64 | Registered clock enable, one bit per peripheral ID |

## Verification
The bench goes after the hard-wired low IDs, the bank boundary, the write-only and unmapped addresses, and the output timing.
- Writing all ones to the first clear register must leave IDs 0 and 1 on. A design that gates them would drop them.
- A set to the second bank that touches bits 0 and 31 must light IDs 32 and 63 and leave the first bank alone. A design that ignores the bank field would alias the write into the first bank.
- Writes aimed at status or unmapped addresses must change no output. A loose decoder would turn them into sets or clears.
- The enable outputs must still show the old value while the strobe is high. A design that drives them combinationally would change within the same cycle.

// File: rtl/pclk_gate_pkg.sv
package pclk_gate_pkg;

    // Register selected by the low address bits inside one bank.
    typedef enum logic [1:0] {
        OP_SET  = 2'd0,
        OP_CLR  = 2'd1,
        OP_STAT = 2'd2,
        OP_NONE = 2'd3
    } reg_op_e;

    // Decoded bus access.
    typedef struct packed {
        logic    hit;
        reg_op_e op;
    } bus_dec_t;

    localparam int unsigned OFFSET_W = 2;

    function automatic reg_op_e op_from_offset(input logic [OFFSET_W-1:0] off);
        reg_op_e r;
        case (off)
            2'd0:    r = OP_SET;
            2'd1:    r = OP_CLR;
            2'd2:    r = OP_STAT;
            default: r = OP_NONE;
        endcase
        return r;
    endfunction

    // Mask of bits inside a bank that can actually be gated.
    function automatic logic [31:0] gate_mask(input int unsigned base_id,
                                              input int unsigned always_on);
        logic [31:0] m;
        for (int unsigned k = 0; k < 32; k++) begin
            m[k] = ((base_id + k) >= always_on);
        end
        return m;
    endfunction

endpackage

// File: rtl/pclk_addr_decode.sv
module pclk_addr_decode
    import pclk_gate_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned NUM_BANKS = 2
) (
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 we_i,
    output logic [NUM_BANKS-1:0] set_o,
    output logic [NUM_BANKS-1:0] clr_o,
    output logic [NUM_BANKS-1:0] rd_o
);
    localparam int unsigned BANK_W = ADDR_W - OFFSET_W;

    bus_dec_t dec;

    always_comb begin
        dec.op  = op_from_offset(addr_i[OFFSET_W-1:0]);
        dec.hit = (32'(addr_i[ADDR_W-1:OFFSET_W]) < NUM_BANKS);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_sel
        logic this_bank;
        assign this_bank = dec.hit && (addr_i[ADDR_W-1:OFFSET_W] == BANK_W'(b));
        assign set_o[b]  = this_bank && we_i && (dec.op == OP_SET);
        assign clr_o[b]  = this_bank && we_i && (dec.op == OP_CLR);
        assign rd_o[b]   = this_bank && (dec.op == OP_STAT);
    end

endmodule

// File: rtl/pclk_enable_bank.sv
module pclk_enable_bank
    import pclk_gate_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned BASE_ID   = 0,
    parameter int unsigned ALWAYS_ON = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic [WORD_W-1:0] mask_i,
    output logic [WORD_W-1:0] en_o
);
    localparam logic [WORD_W-1:0] GATE_MASK = WORD_W'(gate_mask(BASE_ID, ALWAYS_ON));

    logic [WORD_W-1:0] eff_mask;
    assign eff_mask = mask_i & GATE_MASK;

    for (genvar k = 0; k < WORD_W; k++) begin : g_bit
        if (!GATE_MASK[k]) begin : g_fixed
            assign en_o[k] = 1'b1;
        end else begin : g_flop
            logic en_q;
            always_ff @(posedge clk) begin
                if (rst)                         en_q <= 1'b0;
                else if (set_i && eff_mask[k])   en_q <= 1'b1;
                else if (clr_i && eff_mask[k])   en_q <= 1'b0;
            end
            assign en_o[k] = en_q;
        end
    end

    // R1: masked bits are on after a set
    a_r1_set_takes: assert property (@(posedge clk) disable iff (rst)
        set_i |=> ((en_o & $past(mask_i)) == $past(mask_i)));

    // R2 / R6: gateable masked bits are off after a clear
    a_r2_clr_takes: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> ((en_o & $past(mask_i) & GATE_MASK) == '0));

    // R3: zero bits keep their state
    a_r3_zero_bits_hold: assert property (@(posedge clk) disable iff (rst)
        (set_i || clr_i) |=> ((en_o & ~$past(mask_i)) == ($past(en_o) & ~$past(mask_i))));

    // R9: no change without a strobe
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !(set_i || clr_i) |=> $stable(en_o));

    // R7: only fixed bits are on after reset
    a_r7_reset_state: assert property (@(posedge clk)
        rst |=> (en_o == ~GATE_MASK));

endmodule

// File: rtl/pclk_read_mux.sv
module pclk_read_mux #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_BANKS = 2
) (
    input  logic [NUM_BANKS-1:0]        rd_i,
    input  logic [NUM_BANKS*WORD_W-1:0] state_i,
    output logic [WORD_W-1:0]           rdata_o
);
    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            rdata_o = rdata_o | (state_i[b*WORD_W +: WORD_W] & {WORD_W{rd_i[b]}});
        end
    end
endmodule

// File: rtl/pclk_gate_bank.sv
module pclk_gate_bank
    import pclk_gate_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 64,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned ALWAYS_ON  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    input  logic                  bus_we,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic [NUM_PERIPH-1:0] clk_en_o
);
    localparam int unsigned NUM_BANKS = (NUM_PERIPH + WORD_W - 1) / WORD_W;
    localparam int unsigned FLAT_W    = NUM_BANKS * WORD_W;
    localparam int unsigned BANK_W    = ADDR_W - OFFSET_W;

    logic [NUM_BANKS-1:0] set_v, clr_v, rd_v;
    logic [FLAT_W-1:0]    state_flat;

    pclk_addr_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
        .addr_i (bus_addr),
        .we_i   (bus_we),
        .set_o  (set_v),
        .clr_o  (clr_v),
        .rd_o   (rd_v)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pclk_enable_bank #(
            .WORD_W    (WORD_W),
            .BASE_ID   (b * WORD_W),
            .ALWAYS_ON (ALWAYS_ON)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_v[b]),
            .clr_i  (clr_v[b]),
            .mask_i (bus_wdata),
            .en_o   (state_flat[b*WORD_W +: WORD_W])
        );

        // R4 / R5: status read of this bank mirrors its enable lines
        a_r4_status_mirror: assert property (@(posedge clk) disable iff (rst)
            (bus_addr == {BANK_W'(b), 2'd2}) |-> (bus_rdata == state_flat[b*WORD_W +: WORD_W]));
    end

    pclk_read_mux #(.WORD_W(WORD_W), .NUM_BANKS(NUM_BANKS)) u_rd (
        .rd_i    (rd_v),
        .state_i (state_flat),
        .rdata_o (bus_rdata)
    );

    assign clk_en_o = state_flat[NUM_PERIPH-1:0];

    // R5: a write targets at most one register
    a_r5_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({set_v, clr_v}));

    // R8: non-status addresses read as zero
    a_r8_wo_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[OFFSET_W-1:0] != 2'd2) |-> (bus_rdata == '0));

    // R8: writes to status or unmapped space leave outputs alone
    a_r8_ignored_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr[OFFSET_W-1:0] >= 2'd2)) |=> $stable(clk_en_o));

endmodule

// File: tb/pclk_gate_bank_bench.sv
module pclk_gate_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] clk_en_o;

    always #2 clk = ~clk;

    pclk_gate_bank u_pclk_gate_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .clk_en_o  (clk_en_o)
    );

    typedef struct {
        bit          is_read;
        logic [63:0] exp;
        string       req;
    } item_t;

    item_t       sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [63:0] model = 64'h3;
    bit          done = 0;

    task automatic report(input bit ok, input string req, input logic [63:0] act,
                          input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: checks queued expectations just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                if (it.is_read)
                    report(bus_rdata === it.exp[31:0], it.req, {32'h0, bus_rdata}, it.exp);
                else
                    report(clk_en_o === it.exp, it.req, clk_en_o, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        #1;
        report(clk_en_o === model, "R9 output holds during strobe", clk_en_o, model);
        if (a[3:2] < 2) begin
            if (a[1:0] == 2'd0) model[a[2]*32 +: 32] = model[a[2]*32 +: 32] | d;
            if (a[1:0] == 2'd1) model[a[2]*32 +: 32] = model[a[2]*32 +: 32] & ~d;
        end
        model[1:0] = 2'b11;
        sb.push_back('{is_read: 1'b0, exp: model, req: req});
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        sb.push_back('{is_read: 1'b1, exp: {32'h0, e}, req: req});
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        report(clk_en_o === 64'h3, "R7 reset outputs", clk_en_o, 64'h3);
        rd(4'h2, 32'h3, "R7 R6 status bank0 after reset");
        rd(4'h6, 32'h0, "R7 status bank1 after reset");

        wr(4'h0, 32'h0000_00F0, "R1 set bank0");
        rd(4'h2, 32'h0000_00F3, "R4 status bank0 after set");
        wr(4'h0, 32'h0000_0003, "R6 set on fixed IDs");
        wr(4'h1, 32'hFFFF_FFFF, "R2 R6 clear all bank0");
        rd(4'h2, 32'h0000_0003, "R6 fixed IDs still on");
        wr(4'h0, 32'h0000_00F0, "R1 set again");
        wr(4'h1, 32'h0000_0030, "R3 partial clear");
        rd(4'h2, 32'h0000_00C3, "R3 other bits kept");
        wr(4'h4, 32'h8000_0001, "R10 set IDs 32 and 63");
        rd(4'h6, 32'h8000_0001, "R5 R10 status bank1");
        rd(4'h2, 32'h0000_00C3, "R5 bank0 untouched");
        wr(4'h2, 32'hFFFF_FFFF, "R8 write to status ignored");
        wr(4'h3, 32'hFFFF_FFFF, "R8 write to offset 3 ignored");
        wr(4'h8, 32'hFFFF_FFFF, "R8 write to bank 2 ignored");
        rd(4'h0, 32'h0, "R8 set reads zero");
        rd(4'h5, 32'h0, "R8 clear reads zero");
        rd(4'hA, 32'h0, "R8 unmapped bank reads zero");
        wr(4'h5, 32'h8000_0000, "R2 clear ID 63");
        rd(4'h6, 32'h0000_0001, "R2 R10 status bank1 after clear");
        wr(4'h0, 32'hFFFF_FFFF, "R1 set all bank0");
        rd(4'h2, 32'hFFFF_FFFF, "R4 status bank0 full");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule